// File: doc/BRIEF.md
# Pointer-Indexed Register Port with Interrupt Flags

This block is a host bus slave with four directly addressed byte registers behind one chip select. A 2-bit address picks one of them. Register 0 combines four sticky interrupt flags with their enable bits and drives a level interrupt line. Register 1 passes a status byte through to the host. Register 2 is a 6-bit pointer with an optional auto-increment control. Register 3 is a window into a 64-location indirect space that sits outside this block.

Through register 3 the block produces a write strobe, an address and write data for the indirect space, and it returns that space's read data to the host. Locations marked as write-only in a parameter mask read back as zero. The top location is a command strobe: writing it fires a one-cycle pulse and stores nothing. When the auto-increment control is set, the host can stream through consecutive locations without rewriting the pointer.

Reads are combinational from the current state. Their side effects take place at the clock edge that ends the access: the flags clear and the pointer advances.

Top module: `irq_regfile`

## Requirements
- R1: After reset the flags, enables, pointer and auto-increment bit are all zero and `irq` is low.
- R2: A read with `addr`=1 returns `status_in`. A read with `addr`=2 returns auto-increment in bit 7, zero in bit 6 and the pointer in bits 5:0.
- R3: A write with `addr`=2 loads the pointer from `wdata[5:0]` and auto-increment from `wdata[7]`. `ind_addr` shows the new pointer from the next cycle on.
- R4: A write with `addr`=3 to any location except 63 raises `ind_we` in that same cycle, with `ind_addr` equal to the pointer and `ind_wdata` equal to `wdata`.
- R5: A read with `addr`=3 returns `ind_rdata`, except at the write-only locations 0x36, 0x37, 0x3C, 0x3D and 0x3F, which return zero.
- R6: With auto-increment set, every read or write with `addr`=3 advances the pointer by one at the ending edge. With it clear, the pointer is unchanged.
- R7: Auto-increment wraps the pointer from 63 to 0.
- R8: A write with `addr`=3 at location 63 pulses `cmd_strobe` for that cycle and leaves `ind_we` low.
- R9: An `evt[i]` pulse sets flag i, and the flag stays set until it is cleared. The bit order is 0 LTC receive, 1 LTC transmit, 2 video line, 3 timer. A read with `addr`=0 returns the enables in bits 7:4 and the flags in bits 3:0.
- R10: `irq` is high when some flag and its enable are both 1. A write with `addr`=0 loads the enables from `wdata[7:4]` and leaves the flags unchanged.
- R11: A read with `addr`=0 clears all flags at the edge that ends the read.
- R12: An `evt` bit that is high during a read with `addr`=0 leaves its flag set after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Chip select, active high |
| addr | input | 2 | Direct register select |
| wr | input | 1 | Write enable for the access |
| rd | input | 1 | Read enable for the access |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, zero when no read is active |
| irq | output | 1 | Level interrupt request |
| evt | input | 4 | Interrupt source pulses |
| status_in | input | 8 | Byte returned by register 1 |
| ind_addr | output | 6 | Indirect location (current pointer) |
| ind_we | output | 1 | Indirect write strobe |
| ind_wdata | output | 8 | Indirect write data |
| ind_rdata | input | 8 | Indirect read data for `ind_addr` |
| cmd_strobe | output | 1 | One-cycle pulse on a write to location 63 |

## Verification
Read data, `ind_we`, `ind_wdata` and `cmd_strobe` belong to the cycle of the access itself. The bench therefore samples them one time step after it drives the access in the low phase of the clock, before the rising edge. Pointer movement, flag setting and clearing, enable changes and `irq` show up one edge after the access or event. The bench observes those effects in a later access or after the following edge, never in the same cycle as their cause.

// File: rtl/irq_regfile.sv
module irq_regfile #(
  parameter int DW = 8,
  parameter int AW = 6,
  parameter int NLOC = 2 ** AW,
  parameter logic [NLOC-1:0] WO_MASK = 64'hB0C0_0000_0000_0000,
  parameter logic [AW-1:0] CMD_LOC = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic [1:0]    addr,
  input  logic          wr,
  input  logic          rd,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq,
  input  logic [DW/2-1:0] evt,
  input  logic [DW-1:0] status_in,
  output logic [AW-1:0] ind_addr,
  output logic          ind_we,
  output logic [DW-1:0] ind_wdata,
  input  logic [DW-1:0] ind_rdata,
  output logic          cmd_strobe
);
  localparam int NIRQ = DW / 2;
  localparam int PADW = DW - AW - 1;

  logic [NIRQ-1:0] flags, en;
  logic [AW-1:0]   ptr;
  logic            autoinc;

  wire rd0 = cs && rd && addr == 2'd0;
  wire wr0 = cs && wr && addr == 2'd0;
  wire wr2 = cs && wr && addr == 2'd2;
  wire rd3 = cs && rd && addr == 2'd3;
  wire wr3 = cs && wr && addr == 2'd3;
  wire acc3 = rd3 || wr3;

  assign irq        = |(flags & en);
  assign ind_addr   = ptr;
  assign ind_wdata  = wdata;
  assign ind_we     = wr3 && ptr != CMD_LOC;
  assign cmd_strobe = wr3 && ptr == CMD_LOC;

  always_comb begin
    rdata = '0;
    if (cs && rd) begin
      case (addr)
        2'd0: rdata = {en, flags};
        2'd1: rdata = status_in;
        2'd2: rdata = {autoinc, {PADW{1'b0}}, ptr};
        default: rdata = WO_MASK[ptr] ? '0 : ind_rdata;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      en    <= '0;
    end else begin
      flags <= rd0 ? evt : (flags | evt);
      if (wr0) en <= wdata[DW-1:NIRQ];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr     <= '0;
      autoinc <= 1'b0;
    end else if (wr2) begin
      ptr     <= wdata[AW-1:0];
      autoinc <= wdata[DW-1];
    end else if (acc3 && autoinc) begin
      ptr <= ptr + AW'(1);
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !rd0 |=> ((flags & $past(flags)) == $past(flags))); // R9
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0 && evt == '0) |=> flags == '0); // R11
  AST_EVT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    rd0 |=> ((flags & $past(evt)) == $past(evt))); // R12
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc3 && autoinc) |=> ptr == $past(ptr) + AW'(1)); // R7
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc3 && !wr2) |=> $stable(ptr)); // R6
  AST_WO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd3 && WO_MASK[ind_addr]) |-> rdata == '0); // R5
  AST_CMD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_strobe && ind_we)); // R8
endmodule

// File: tb/tb_irq_regfile.sv
module tb_irq_regfile;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, cs = 0, wr = 0, rd = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata, status_in = 8'h5A, ind_wdata, ind_rdata;
  logic [3:0] evt = 0;
  logic irq, ind_we, cmd_strobe;
  logic [5:0] ind_addr;
  logic [7:0] mem [64];
  int errors = 0, checks = 0;
  logic [7:0] rv;
  logic we_s, cmd_s;
  logic [5:0] ia_s;
  logic [7:0] iw_s;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_regfile dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr), .wr(wr), .rd(rd),
    .wdata(wdata), .rdata(rdata), .irq(irq), .evt(evt), .status_in(status_in),
    .ind_addr(ind_addr), .ind_we(ind_we), .ind_wdata(ind_wdata),
    .ind_rdata(ind_rdata), .cmd_strobe(cmd_strobe)
  );

  assign ind_rdata = mem[ind_addr];
  always @(posedge clk) if (ind_we) mem[ind_addr] <= ind_wdata;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_rd(input logic [1:0] a, input logic [3:0] ev, output logic [7:0] d);
    @(negedge clk);
    cs = 1; rd = 1; addr = a; evt = ev;
    #1 d = rdata;
    @(posedge clk); #1;
    cs = 0; rd = 0; evt = 0;
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = 1; wr = 1; addr = a; wdata = d;
    #1 we_s = ind_we; cmd_s = cmd_strobe; ia_s = ind_addr; iw_s = ind_wdata;
    @(posedge clk); #1;
    cs = 0; wr = 0;
  endtask

  task automatic pulse(input logic [3:0] ev);
    @(negedge clk); evt = ev;
    @(posedge clk); #1 evt = 0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 ind_addr", {2'd0, ind_addr}, 8'h00);
    bus_rd(2'd0, 4'd0, rv); chk("R1 reg0", rv, 8'h00);
    bus_rd(2'd2, 4'd0, rv); chk("R1 reg2", rv, 8'h00);
  endtask

  task automatic t_direct;
    bus_rd(2'd1, 4'd0, rv); chk("R2 reg1", rv, 8'h5A);
    bus_wr(2'd1, 8'hFF);
    bus_wr(2'd2, 8'h85);
    bus_rd(2'd2, 4'd0, rv); chk("R2 R3 reg2", rv, 8'h85);
    chk("R3 ind_addr", {2'd0, ind_addr}, 8'h05);
  endtask

  task automatic t_indirect_write;
    bus_wr(2'd3, 8'h3C);
    chk("R4 ind_we", {7'd0, we_s}, 8'h01);
    chk("R4 ind_addr", {2'd0, ia_s}, 8'h05);
    chk("R4 ind_wdata", iw_s, 8'h3C);
    bus_rd(2'd2, 4'd0, rv); chk("R6 inc after write", rv, 8'h86);
  endtask

  task automatic t_indirect_read;
    bus_wr(2'd2, 8'h10);
    bus_wr(2'd3, 8'hAA);
    bus_rd(2'd3, 4'd0, rv); chk("R5 read back", rv, 8'hAA);
    bus_rd(2'd2, 4'd0, rv); chk("R6 no inc", rv, 8'h10);
    bus_wr(2'd2, 8'h36);
    bus_wr(2'd3, 8'h77);
    chk("R4 wo write strobe", {7'd0, we_s}, 8'h01);
    bus_rd(2'd3, 4'd0, rv); chk("R5 wo 0x36", rv, 8'h00);
    bus_wr(2'd2, 8'h3D);
    bus_wr(2'd3, 8'h11);
    bus_rd(2'd3, 4'd0, rv); chk("R5 wo 0x3D", rv, 8'h00);
    bus_wr(2'd2, 8'h05);
    bus_rd(2'd3, 4'd0, rv); chk("R5 earlier write", rv, 8'h3C);
  endtask

  task automatic t_cmd_and_wrap;
    bus_wr(2'd2, 8'h3F);
    bus_wr(2'd3, 8'h99);
    chk("R8 cmd_strobe", {7'd0, cmd_s}, 8'h01);
    chk("R8 no ind_we", {7'd0, we_s}, 8'h00);
    bus_wr(2'd2, 8'hBF);
    bus_rd(2'd3, 4'd0, rv); chk("R5 wo 0x3F", rv, 8'h00);
    bus_rd(2'd2, 4'd0, rv); chk("R7 wrap", rv, 8'h80);
  endtask

  task automatic t_irq;
    bus_wr(2'd0, 8'h10);
    pulse(4'b0100);
    @(negedge clk); chk("R10 masked irq", {7'd0, irq}, 8'h00);
    pulse(4'b0001);
    @(negedge clk); chk("R10 irq set", {7'd0, irq}, 8'h01);
    bus_wr(2'd0, 8'h0F);
    @(negedge clk); chk("R10 irq off", {7'd0, irq}, 8'h00);
    bus_rd(2'd0, 4'd0, rv); chk("R9 R10 flags kept", rv, 8'h05);
    bus_rd(2'd0, 4'd0, rv); chk("R11 cleared", rv, 8'h00);
  endtask

  task automatic t_collision;
    bus_wr(2'd0, 8'hF0);
    bus_rd(2'd0, 4'b1000, rv); chk("R12 read value", rv, 8'hF0);
    @(negedge clk); chk("R12 irq", {7'd0, irq}, 8'h01);
    bus_rd(2'd0, 4'd0, rv); chk("R12 flag kept", rv, 8'hF8);
    bus_rd(2'd0, 4'd0, rv); chk("R11 clear", rv, 8'hF0);
    @(negedge clk); chk("R11 irq low", {7'd0, irq}, 8'h00);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'(i);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset;
    t_direct;
    t_indirect_write;
    t_indirect_read;
    t_cmd_and_wrap;
    t_irq;
    t_collision;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule